// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This block sits between a set of peripheral interrupt request lines and a processor core. It takes seven active-low request lines, each standing for one priority level from 1 (lowest) to 7 (highest), and brings them into the clock domain through a two-stage synchroniser. It reduces the active lines to the 3-bit code of the highest level requesting. That code goes to the core as an active-low level, where all ones means nothing is pending.

The same level is compared with the 3-bit interrupt mask from the core's status register. A flag says whether the pending level is high enough to be taken. When the core runs its acknowledge cycle, the block decodes that cycle into one of seven active-low acknowledge lines, one for each level. The core marks the cycle by driving function code 111 (CPU space) with the address strobe low, and it carries the level being serviced on address bits A3..A1. Vector fetch and stack work are left to other logic.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, `ipl_n` reads 3'b111, `take_irq` reads 0 and every bit of `iack_n` reads 1.
- R2: Request bit `irq_n[k-1]` low stands for level k (k = 1..7). With only that line low, `ipl_n` equals the bitwise inverse of k, three rising clock edges after the line changes.
- R3: When several request lines are low at once, `ipl_n` carries the inverse of the highest level among them.
- R4: With every request line high, `ipl_n` returns to 3'b111 three rising edges after the last line is released.
- R5: `take_irq` is 1 only when the pending level (the inverse of `ipl_n`) is strictly greater than `mask`. A level equal to the mask, or below it, gives 0. The flag follows a change of `mask` in the same cycle.
- R6: With `fc` = 3'b111, `as_n` low and `ack_lvl` = k in 1..7, exactly bit k-1 of `iack_n` is low one rising edge later, and all other bits are high.
- R7: When `fc` is anything other than 3'b111, no bit of `iack_n` is low one rising edge later, whatever the strobe and address are.
- R8: When `as_n` is high, every bit of `iack_n` is high one rising edge later.
- R9: An acknowledge cycle that carries level 0 on `ack_lvl` asserts no acknowledge line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_n | input | 7 | Active-low requests; bit k-1 is level k |
| mask | input | 3 | Interrupt mask from the status register |
| fc | input | 3 | Function code of the current bus cycle |
| ack_lvl | input | 3 | Address bits A3..A1 during the bus cycle |
| as_n | input | 1 | Active-low address strobe |
| ipl_n | output | 3 | Active-low encoded pending level |
| take_irq | output | 1 | Pending level exceeds mask |
| iack_n | output | 7 | Active-low acknowledge lines; bit k-1 is level k |

## Verification
If the level register holds a wrong value, it shows on `ipl_n` and through `take_irq` three edges after the request lines change. A fault in the request synchroniser shows the same way, so each directed request pattern exposes it within three cycles. If the acknowledge register holds a wrong value, it shows on `iack_n` one edge after the bus cycle is presented. The checker asks that at most one line is low, and that every line is high one edge after the strobe rises or the function code leaves CPU space. A decode that points to the wrong line is therefore caught in the first acknowledge cycle that uses that level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LEVELS  = 7;
  localparam int FC_W        = 3;
  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
endpackage

// File: rtl/irq_bit_sync.sv
module irq_bit_sync #(
  parameter int   W       = 7,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[g] <= RST_VAL;
        stage2_q[g] <= RST_VAL;
      end else begin
        stage1_q[g] <= d_async[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_LEVELS = 7,
  localparam int LVL_W   = $clog2(N_LEVELS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] req_n,
  input  logic [LVL_W-1:0]    mask,
  output logic [LVL_W-1:0]    lvl,
  output logic                above_mask
);
  logic [LVL_W-1:0] lvl_d;
  logic [LVL_W-1:0] lvl_q;

  always_comb begin
    lvl_d = '0;
    for (int i = 0; i < N_LEVELS; i++) begin
      if (!req_n[i]) lvl_d = LVL_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign lvl        = lvl_q;
  assign above_mask = (lvl_q > mask);
endmodule

// File: rtl/iack_decode.sv
module iack_decode #(
  parameter int N_LEVELS = 7,
  localparam int LVL_W   = $clog2(N_LEVELS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_space,
  input  logic                strobe,
  input  logic [LVL_W-1:0]    lvl,
  output logic [N_LEVELS-1:0] ack_n
);
  logic [N_LEVELS-1:0] ack_n_d;
  logic [N_LEVELS-1:0] ack_n_q;
  logic                cyc_en;

  assign cyc_en = cpu_space && strobe;

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_line
    assign ack_n_d[g] = !(cyc_en && (lvl == LVL_W'(g + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_n_q <= '1;
    else        ack_n_q <= ack_n_d;
  end

  assign ack_n = ack_n_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_LEVELS = irq_pkg::IRQ_LEVELS,
  localparam int LVL_W   = $clog2(N_LEVELS + 1),
  localparam int FC_W    = irq_pkg::FC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] irq_n,
  input  logic [LVL_W-1:0]    mask,
  input  logic [FC_W-1:0]     fc,
  input  logic [LVL_W-1:0]    ack_lvl,
  input  logic                as_n,
  output logic [LVL_W-1:0]    ipl_n,
  output logic                take_irq,
  output logic [N_LEVELS-1:0] iack_n
);
  logic                rst_meta_q;
  logic                rst_sync_n;
  logic [N_LEVELS-1:0] req_sync_n;
  logic [LVL_W-1:0]    cur_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irq_bit_sync #(.W(N_LEVELS), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (irq_n),
    .q_sync  (req_sync_n)
  );

  irq_prio_enc #(.N_LEVELS(N_LEVELS)) u_enc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_n      (req_sync_n),
    .mask       (mask),
    .lvl        (cur_lvl),
    .above_mask (take_irq)
  );

  iack_decode #(.N_LEVELS(N_LEVELS)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_space (fc == irq_pkg::FC_CPU_SPACE),
    .strobe    (!as_n),
    .lvl       (ack_lvl),
    .ack_n     (iack_n)
  );

  assign ipl_n = ~cur_lvl;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_LEVELS = 7,
  localparam int LVL_W   = $clog2(N_LEVELS + 1)
) (
  input logic                clk,
  input logic                rst_ok,
  input logic [LVL_W-1:0]    mask,
  input logic [2:0]          fc,
  input logic [LVL_W-1:0]    ack_lvl,
  input logic                as_n,
  input logic [LVL_W-1:0]    ipl_n,
  input logic                take_irq,
  input logic [N_LEVELS-1:0] iack_n
);
  // R6: at most one acknowledge line low
  a_r6_iack_onehot: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(~iack_n));

  // R6: matching line selected one edge after an acknowledge cycle
  a_r6_iack_match: assert property (@(posedge clk) disable iff (!rst_ok)
    (fc == 3'b111 && !as_n && ack_lvl != '0) |=>
      (iack_n == ~(N_LEVELS'(1) << ($past(ack_lvl) - 1'b1))));

  // R7: no acknowledge outside CPU space
  a_r7_need_cpu_space: assert property (@(posedge clk) disable iff (!rst_ok)
    (fc != 3'b111) |=> (iack_n == '1));

  // R8: strobe inactive releases every line
  a_r8_strobe_release: assert property (@(posedge clk) disable iff (!rst_ok)
    as_n |=> (iack_n == '1));

  // R9: level zero selects nothing
  a_r9_zero_level: assert property (@(posedge clk) disable iff (!rst_ok)
    (ack_lvl == '0) |=> (iack_n == '1));

  // R4/R5: idle level never requests service
  a_r5_idle_no_take: assert property (@(posedge clk) disable iff (!rst_ok)
    (ipl_n == '1) |-> !take_irq);

  // R5: a mask of all ones blocks every level
  a_r5_full_mask: assert property (@(posedge clk) disable iff (!rst_ok)
    (mask == '1) |-> !take_irq);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_LEVELS(N_LEVELS)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .mask     (mask),
  .fc       (fc),
  .ack_lvl  (ack_lvl),
  .as_n     (as_n),
  .ipl_n    (ipl_n),
  .take_irq (take_irq),
  .iack_n   (iack_n)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] irq_n;
  logic [2:0] mask;
  logic [2:0] fc;
  logic [2:0] ack_lvl;
  logic       as_n;
  logic [2:0] ipl_n;
  logic       take_irq;
  logic [6:0] iack_n;

  int n_checks = 0;
  int n_bad    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask(mask), .fc(fc),
    .ack_lvl(ack_lvl), .as_n(as_n), .ipl_n(ipl_n), .take_irq(take_irq),
    .iack_n(iack_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle_req(input logic [6:0] v);
    irq_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; irq_n = '1; mask = 3'd0; fc = 3'b001; ack_lvl = 3'd0; as_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ipl_n in reset", ipl_n, 3'b111);
    check("R1 take_irq in reset", take_irq, 0);
    check("R1 iack_n in reset", iack_n, 7'h7f);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 iack_n after release", iack_n, 7'h7f);
    check("R1 ipl_n after release", ipl_n, 3'b111);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_single;
    for (int k = 1; k <= 7; k++) begin
      settle_req(~(7'd1 << (k - 1)));
      check($sformatf("R2 single level %0d", k), ipl_n, (~k) & 7);
    end
  endtask

  task automatic t_latency;
    irq_n = '1; repeat (4) @(negedge clk);
    irq_n = 7'b1111011;
    repeat (2) @(negedge clk);
    check("R2 not yet visible after two edges", ipl_n, 3'b111);
    @(negedge clk);
    check("R2 visible after three edges", ipl_n, 3'b100);
  endtask

  task automatic t_multi;
    settle_req(7'b0101010);
    check("R3 levels 1,3,5,7 give 7", ipl_n, 3'b000);
    settle_req(7'b1100110);
    check("R3 levels 1,4,5 give 5", ipl_n, 3'b010);
    settle_req(7'b1111100);
    check("R3 levels 1,2 give 2", ipl_n, 3'b101);
  endtask

  task automatic t_none;
    settle_req(7'b0000000);
    check("R3 all low give 7", ipl_n, 3'b000);
    settle_req(7'h7f);
    check("R4 idle level", ipl_n, 3'b111);
    mask = 3'd0; #1;
    check("R4 idle take_irq", take_irq, 0);
  endtask

  task automatic t_mask;
    settle_req(7'b1101111);            // level 5
    mask = 3'd4; #1;
    check("R5 level 5 over mask 4", take_irq, 1);
    mask = 3'd5; #1;
    check("R5 level 5 equal mask 5", take_irq, 0);
    mask = 3'd6; #1;
    check("R5 level 5 under mask 6", take_irq, 0);
    settle_req(7'b0111111);            // level 7
    mask = 3'd7; #1;
    check("R5 level 7 equal mask 7", take_irq, 0);
    mask = 3'd6; #1;
    check("R5 level 7 over mask 6", take_irq, 1);
    settle_req(7'b1111110);
    mask = 3'd0; #1;
    check("R5 level 1 over mask 0", take_irq, 1);
  endtask

  task automatic t_ack;
    for (int k = 1; k <= 7; k++) begin
      fc = 3'b111; as_n = 1'b0; ack_lvl = 3'(k);
      @(negedge clk);
      check($sformatf("R6 ack level %0d", k), iack_n, (~(1 << (k - 1))) & 8'h7f);
    end
    as_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_wrong_fc;
    for (int f = 0; f < 7; f++) begin
      fc = 3'(f); as_n = 1'b0; ack_lvl = 3'd3;
      @(negedge clk);
      check($sformatf("R7 fc %0d gives no ack", f), iack_n, 7'h7f);
    end
  endtask

  task automatic t_strobe;
    fc = 3'b111; ack_lvl = 3'd6; as_n = 1'b0;
    @(negedge clk);
    check("R8 ack asserted before release", iack_n, 7'b1011111);
    as_n = 1'b1;
    @(negedge clk);
    check("R8 released one edge after strobe", iack_n, 7'h7f);
    as_n = 1'b1; ack_lvl = 3'd2;
    @(negedge clk);
    check("R8 no ack with strobe high", iack_n, 7'h7f);
  endtask

  task automatic t_zero;
    fc = 3'b111; ack_lvl = 3'd0; as_n = 1'b0;
    @(negedge clk);
    check("R9 level zero selects none", iack_n, 7'h7f);
    as_n = 1'b1; fc = 3'b001;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_single();
    t_latency();
    t_multi();
    t_none();
    t_mask();
    t_ack();
    t_wrong_fc();
    t_strobe();
    t_zero();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule